// File: doc/BRIEF.md
# Interface Adapter Register Bank with Interval Timers

This block is a byte-wide peripheral register file with sixteen registers. A host bus selects one of them through a 4-bit index taken from the top four address bits (bits 12:9 with the default 13-bit address). Most registers are plain storage: two port data bytes, a second copy of the A data byte with no handshake side effect, two direction bytes, the shift byte, and the auxiliary and peripheral control bytes. No port pins and no transfer handshake are driven from here.

Two 16-bit down-counters share one clock prescaler. Timer 1 reloads from a programmable 16-bit latch. Timer 2 always wraps to 0xFFFF. When the auxiliary control byte selects continuous mode, each timer 1 wrap raises a flag. An interrupt flag byte and an interrupt enable byte sit beside the timers. Flags are cleared by writing ones. Enables are set or cleared in groups, selected by bit 7 of the written byte. Only the shift-complete source drives the single interrupt output. An external `shift_done` pulse raises that source.

Top module: `ifa_regbank`

## Requirements
- R1: The register index is address bits [12:9], and all lower address bits are ignored. Indices 0 (B data), 1 (A data), 2 (B direction), 3 (A direction), 10 (shift byte), 11 (auxiliary control), 12 (peripheral control) and 15 (A data, no handshake) each read back the last byte written to them.
- R2: After a synchronous active-low reset, both counters hold 0xFFFF. The timer 1 latch reads 0x0000, which stands for a 65536-count period. All other registers read 0x00, and `irq` is low.
- R3: Each counter decrements once every PRESCALE clocks. A write to any counter byte (index 4, 5, 8 or 9) restarts the shared prescaler, so the first decrement lands on the PRESCALE-th clock edge after the write edge.
- R4: Writing a counter low byte (index 4 or 8) or high byte (index 5 or 9) replaces only that byte of the count and keeps the other byte at its current value.
- R5: On a tick while the count is zero, timer 1 reloads with latch minus one, modulo 65536, and timer 2 reloads with 0xFFFF. The timer 1 latch is written and read at index 6 (low byte) and index 7 (high byte).
- R6: When auxiliary control bits [7:6] equal 01, each timer 1 wrap sets flag bit 6 (index 13). In any other mode, a wrap leaves that flag unchanged.
- R7: A read of index 4 or index 5 clears flag bit 6, unless a timer 1 wrap sets it on the same edge.
- R8: Writing index 13 clears each flag bit written as one. A hardware set on the same edge wins over the clear.
- R9: Writing index 14 with bit 7 set ORs bits [6:0] into the enables. With bit 7 clear, it clears each enable bit written as one. Reading index 14 returns bit 7 as 0.
- R10: A `shift_done` pulse sets flag bit 2. `irq` is high exactly when flag bit 2 and enable bit 2 are both set. Flag bit 6 never drives `irq`, even when it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_rd | input | 1 | Read strobe; its side effects occur at the clock edge |
| bus_addr | input | ADDR_W | Bus address; the top four bits select the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| shift_done | input | 1 | One-cycle pulse from the shift logic; sets flag bit 2 |
| irq | output | 1 | Interrupt request |

## Verification
A counter that is off by one or reloads with the wrong value shows on the next read of its bytes, and that value differs within PRESCALE clocks. A flag-bit error in timer 1 logic never reaches `irq`. It therefore shows only when the flag byte is read, the read right after a wrap or an acknowledge. A wrong flag or enable bit 2 shows on `irq` within the same cycle. The bench places counter reads at exact edge counts after a write, so that a misplaced prescaler restart gives a different byte.

// File: rtl/ifa_pkg.sv
// Package: shared register indices, flag positions and mode codes for the
// interface adapter register bank. Assumes 8-bit registers and 16-bit timers.
package ifa_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;
    localparam int FLAG_W = 7;
    localparam int IDX_W  = 4;
    localparam int N_TMR  = 2;

    typedef enum logic [IDX_W-1:0] {
        IX_PORTB   = 4'd0,
        IX_PORTA   = 4'd1,
        IX_DIRB    = 4'd2,
        IX_DIRA    = 4'd3,
        IX_T1_LO   = 4'd4,
        IX_T1_HI   = 4'd5,
        IX_T1L_LO  = 4'd6,
        IX_T1L_HI  = 4'd7,
        IX_T2_LO   = 4'd8,
        IX_T2_HI   = 4'd9,
        IX_SHIFT   = 4'd10,
        IX_AUXCTL  = 4'd11,
        IX_PERCTL  = 4'd12,
        IX_FLAGS   = 4'd13,
        IX_ENABLES = 4'd14,
        IX_PORTA_NH = 4'd15
    } reg_idx_e;

    localparam int FLG_SHIFT = 2;
    localparam int FLG_T1    = 6;
    localparam logic [1:0] T1_CONTINUOUS = 2'b01;
endpackage

// File: rtl/ifa_prescaler.sv
// Module: shared prescaler. Emits a one-cycle tick every PRESCALE clocks.
// Assumes PRESCALE >= 2. A restart pulse returns the phase to zero, so the
// next tick follows PRESCALE clocks after the restart edge.
module ifa_prescaler #(
    parameter int PRESCALE = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] phase;

    // Tick on the last phase of each period.
    assign tick = (phase == LAST);

    // Advance the phase; clear it on restart or at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (restart) phase <= '0;
        else if (tick)    phase <= '0;
        else              phase <= phase + 1'b1;
    end

    // R3: the phase never leaves its range.
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);
    // R3: a restart holds the tick off on the following cycle.
    p_restart_delays_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
endmodule

// File: rtl/ifa_timer.sv
// Module: one 16-bit down-counter with byte loads. Writes take priority over
// the tick. A tick at zero loads the reload value and pulses wrap.
// Assumes the reload value is supplied by the parent.
module ifa_timer
    import ifa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  reload,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    // Wrap happens on a tick taken while the count is zero.
    assign wrap = tick && (count == '0) && !wr_lo && !wr_hi;

    // Byte loads, then decrement or reload.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '1;
        else if (wr_lo) count <= {count[CNT_W-1:DATA_W], wdata};
        else if (wr_hi) count <= {wdata, count[DATA_W-1:0]};
        else if (tick)  count <= (count == '0) ? reload : count - 1'b1;
    end

    // R3: an undisturbed tick from a nonzero count decrements by one.
    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lo && !wr_hi && count != '0) |=> count == $past(count) - 1'b1);
    // R5: a wrap loads the reload value.
    p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count == $past(reload));
    // R4: a low-byte write keeps the high byte.
    p_lo_keeps_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> count[CNT_W-1:DATA_W] == $past(count[CNT_W-1:DATA_W]));
endmodule

// File: rtl/ifa_irq_ctrl.sv
// Module: interrupt flag and enable bytes with the interrupt output.
// A hardware set wins over a clear on the same edge. Only flag bit 2,
// when enabled, raises the interrupt. Assumes single-cycle set pulses.
module ifa_irq_ctrl
    import ifa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic              flags_wr,
    input  logic              enables_wr,
    input  logic              t1_ack,
    input  logic [DATA_W-1:0] wdata,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] enables,
    output logic              irq
);
    logic [FLAG_W-1:0] clr_vec;

    // Build the clear mask from software writes and timer 1 acknowledges.
    always_comb begin
        clr_vec = flags_wr ? wdata[FLAG_W-1:0] : '0;
        if (t1_ack) clr_vec[FLG_T1] = 1'b1;
    end

    // Flag byte: clear, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    // Enable byte: bit 7 of the write picks group set or group clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enables <= '0;
        else if (enables_wr)
            enables <= wdata[DATA_W-1] ? (enables | wdata[FLAG_W-1:0])
                                       : (enables & ~wdata[FLAG_W-1:0]);
    end

    // Only the shift-complete source reaches the output.
    assign irq = flags[FLG_SHIFT] & enables[FLG_SHIFT];

    // R9: a group-set write leaves every written bit enabled.
    p_enable_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enables_wr && wdata[DATA_W-1]) |=>
            (enables & $past(wdata[FLAG_W-1:0])) == $past(wdata[FLAG_W-1:0]));
    // R8: a clear write removes the written bits that no set reasserts.
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flags_wr |=> (flags & $past(wdata[FLAG_W-1:0]) & ~$past(set_vec)) == '0);
    // R7: an acknowledge clears the timer 1 flag unless a wrap sets it again.
    p_t1_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_ack && !set_vec[FLG_T1]) |=> !flags[FLG_T1]);
    // R10: a shift pulse always leaves flag bit 2 set.
    p_shift_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[FLG_SHIFT] |=> flags[FLG_SHIFT]);
endmodule

// File: rtl/ifa_regbank.sv
// Module: top of the interface adapter register bank. It decodes the
// register index from the top four address bits and holds the plain storage
// bytes. It contains the two timers, the shared prescaler and the interrupt
// logic. Read data is combinational. Read side effects and writes occur at
// the clock edge. Assumes reg_wr and reg_rd are never high together.
module ifa_regbank
    import ifa_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int PRESCALE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              shift_done,
    output logic              irq
);
    reg_idx_e idx;
    logic [DATA_W-1:0] port_b, port_a, dir_b, dir_a, shreg, auxctl, perctl, port_a_nh;
    logic [CNT_W-1:0]  t1_latch;
    logic [CNT_W-1:0]  cnt    [N_TMR];
    logic [CNT_W-1:0]  reload [N_TMR];
    logic [N_TMR-1:0]  wr_lo, wr_hi, wrap;
    logic              tick, restart, t1_cont, t1_ack;
    logic [FLAG_W-1:0] flags, enables, set_vec;

    // Register index from the top address bits.
    assign idx = reg_idx_e'(bus_addr[ADDR_W-1 -: IDX_W]);

    // Counter byte write strobes.
    assign wr_lo[0] = reg_wr && idx == IX_T1_LO;
    assign wr_hi[0] = reg_wr && idx == IX_T1_HI;
    assign wr_lo[1] = reg_wr && idx == IX_T2_LO;
    assign wr_hi[1] = reg_wr && idx == IX_T2_HI;
    assign restart  = |{wr_lo, wr_hi};

    // Reload values: timer 1 from its latch, timer 2 full range.
    assign reload[0] = t1_latch - 1'b1;
    assign reload[1] = '1;

    ifa_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    // Two timers of identical structure.
    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        ifa_timer u_tmr (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(wdata),
            .reload(reload[i]), .count(cnt[i]), .wrap(wrap[i])
        );
    end

    // Interrupt sources and timer 1 acknowledge.
    assign t1_cont = (auxctl[7:6] == T1_CONTINUOUS);
    assign t1_ack  = reg_rd && (idx == IX_T1_LO || idx == IX_T1_HI);
    always_comb begin
        set_vec            = '0;
        set_vec[FLG_T1]    = wrap[0] && t1_cont;
        set_vec[FLG_SHIFT] = shift_done;
    end

    ifa_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .flags_wr(reg_wr && idx == IX_FLAGS),
        .enables_wr(reg_wr && idx == IX_ENABLES),
        .t1_ack(t1_ack), .wdata(wdata),
        .flags(flags), .enables(enables), .irq(irq)
    );

    // Plain storage and latch writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_b <= '0; port_a <= '0; dir_b <= '0; dir_a <= '0;
            shreg <= '0; auxctl <= '0; perctl <= '0; port_a_nh <= '0;
            t1_latch <= '0;
        end else if (reg_wr) begin
            case (idx)
                IX_PORTB:    port_b    <= wdata;
                IX_PORTA:    port_a    <= wdata;
                IX_DIRB:     dir_b     <= wdata;
                IX_DIRA:     dir_a     <= wdata;
                IX_T1L_LO:   t1_latch[DATA_W-1:0]     <= wdata;
                IX_T1L_HI:   t1_latch[CNT_W-1:DATA_W] <= wdata;
                IX_SHIFT:    shreg     <= wdata;
                IX_AUXCTL:   auxctl    <= wdata;
                IX_PERCTL:   perctl    <= wdata;
                IX_PORTA_NH: port_a_nh <= wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (idx)
            IX_PORTB:    rdata = port_b;
            IX_PORTA:    rdata = port_a;
            IX_DIRB:     rdata = dir_b;
            IX_DIRA:     rdata = dir_a;
            IX_T1_LO:    rdata = cnt[0][DATA_W-1:0];
            IX_T1_HI:    rdata = cnt[0][CNT_W-1:DATA_W];
            IX_T1L_LO:   rdata = t1_latch[DATA_W-1:0];
            IX_T1L_HI:   rdata = t1_latch[CNT_W-1:DATA_W];
            IX_T2_LO:    rdata = cnt[1][DATA_W-1:0];
            IX_T2_HI:    rdata = cnt[1][CNT_W-1:DATA_W];
            IX_SHIFT:    rdata = shreg;
            IX_AUXCTL:   rdata = auxctl;
            IX_PERCTL:   rdata = perctl;
            IX_FLAGS:    rdata = {1'b0, flags};
            IX_ENABLES:  rdata = {1'b0, enables};
            default:     rdata = port_a_nh;
        endcase
    end

    // R1: a write to the auxiliary control index is held for readback.
    p_auxctl_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && idx == IX_AUXCTL) |=> auxctl == $past(wdata));
    // R6: outside continuous mode no edge raises the timer 1 flag.
    p_no_flag_outside_cont_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!t1_cont && !flags[FLG_T1]) |=> !flags[FLG_T1]);
    // R10: a rise of irq needs the shift flag.
    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> flags[FLG_SHIFT]);
endmodule

// File: tb/tb_ifa_regbank.sv
// Bench: directed scenarios, one task each; results are compared at negedges.
module tb_ifa_regbank;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        shift_done = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rv;

    ifa_regbank #(.ADDR_W(13), .PRESCALE(PS)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .bus_addr(bus_addr), .wdata(wdata), .rdata(rdata),
        .shift_done(shift_done), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // Low address bits are filled with junk to show they are ignored.
    function automatic logic [12:0] adr(input int ix);
        return {ix[3:0], 9'h1A5};
    endfunction

    // Write at the current negedge, accepted at the next posedge.
    task automatic wr(input int ix, input logic [7:0] d);
        bus_addr = adr(ix); wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Read: sample now, side effect at the next posedge.
    task automatic rd(input int ix, output logic [7:0] d);
        bus_addr = adr(ix); reg_rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset;
        rd(4, rv); check("R2 t1 lo", rv, 8'hFF);
        rd(5, rv); check("R2 t1 hi", rv, 8'hFF);
        rd(9, rv); check("R2 t2 hi", rv, 8'hFF);
        rd(6, rv); check("R2 latch lo", rv, 8'h00);
        rd(7, rv); check("R2 latch hi", rv, 8'h00);
        rd(13, rv); check("R2 flags", rv, 8'h00);
        rd(14, rv); check("R2 enables", rv, 8'h00);
        rd(11, rv); check("R2 auxctl", rv, 8'h00);
        check("R2 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_storage;
        wr(0, 8'hA1); wr(1, 8'hB2); wr(2, 8'hC3); wr(3, 8'hD4);
        wr(10, 8'hE5); wr(11, 8'h9A); wr(12, 8'h37); wr(15, 8'h6C);
        rd(0, rv);  check("R1 portb", rv, 8'hA1);
        rd(1, rv);  check("R1 porta", rv, 8'hB2);
        rd(2, rv);  check("R1 dirb", rv, 8'hC3);
        rd(3, rv);  check("R1 dira", rv, 8'hD4);
        rd(10, rv); check("R1 shift", rv, 8'hE5);
        rd(11, rv); check("R1 auxctl", rv, 8'h9A);
        rd(12, rv); check("R1 perctl", rv, 8'h37);
        rd(15, rv); check("R1 porta nh", rv, 8'h6C);
        wr(11, 8'h00);
    endtask

    task automatic t_byte_load;
        wr(8, 8'h56); wr(9, 8'h34);
        rd(9, rv); check("R4 t2 hi", rv, 8'h34);
        rd(8, rv); check("R4 t2 lo", rv, 8'h56);
        wr(8, 8'h78);
        rd(9, rv); check("R4 hi kept", rv, 8'h34);
        rd(8, rv); check("R4 lo new", rv, 8'h78);
    endtask

    task automatic t_t2_wrap;
        wr(8, 8'h01); wr(9, 8'h00);        // E0: count 1
        rd(8, rv); check("R3 t2 at E0", rv, 8'h01);
        repeat (2) @(negedge clk);
        rd(8, rv); check("R3 t2 before tick", rv, 8'h01);
        rd(8, rv); check("R3 t2 after E4", rv, 8'h00);
        repeat (3) @(negedge clk);
        rd(9, rv); check("R5 t2 wrap hi", rv, 8'hFF);
        rd(8, rv); check("R5 t2 wrap lo", rv, 8'hFF);
    endtask

    task automatic t_t1_cont;
        wr(14, 8'hC0);                     // enable bit 6
        wr(6, 8'h05); wr(7, 8'h00);
        rd(6, rv); check("R5 latch lo", rv, 8'h05);
        wr(11, 8'h40);                     // continuous mode
        wr(4, 8'h02); wr(5, 8'h00);        // E0: count 2
        rd(4, rv); check("R3 t1 at E0", rv, 8'h02);
        repeat (2) @(negedge clk);
        rd(4, rv); check("R3 t1 at E3", rv, 8'h02);
        rd(4, rv); check("R3 t1 at E4", rv, 8'h01);
        repeat (6) @(negedge clk);
        rd(13, rv); check("R6 no flag before wrap", rv, 8'h00);
        rd(13, rv); check("R6 flag at wrap", rv, 8'h40);
        check("R10 t1 flag does not drive irq", {7'b0, irq}, 8'h00);
        rd(4, rv); check("R5 t1 reload", rv, 8'h04);
        rd(13, rv); check("R7 ack clears flag", rv, 8'h00);
    endtask

    task automatic t_t1_oneshot;
        wr(11, 8'h00);
        wr(4, 8'h00); wr(5, 8'h00);        // E0: count 0
        repeat (4) @(negedge clk);
        rd(4, rv); check("R5 reload without flag mode", rv, 8'h04);
        rd(13, rv); check("R6 no flag outside mode", rv, 8'h00);
        wr(14, 8'h40);                     // clear enable bit 6
        rd(14, rv); check("R9 group clear", rv, 8'h00);
    endtask

    task automatic t_irq;
        shift_done = 1'b1; @(negedge clk); shift_done = 1'b0;
        rd(13, rv); check("R10 shift flag", rv, 8'h04);
        check("R10 irq masked", {7'b0, irq}, 8'h00);
        wr(14, 8'h84);
        check("R10 irq on", {7'b0, irq}, 8'h01);
        rd(14, rv); check("R9 enable bit7 reads 0", rv, 8'h04);
        wr(14, 8'h04);
        check("R9 disable drops irq", {7'b0, irq}, 8'h00);
        wr(14, 8'h84);
        shift_done = 1'b1; wr(13, 8'h04); shift_done = 1'b0;
        check("R8 set wins over clear", {7'b0, irq}, 8'h01);
        wr(13, 8'h7F);
        rd(13, rv); check("R8 write-one clears", rv, 8'h00);
        check("R10 irq off", {7'b0, irq}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_storage;
        t_byte_load;
        t_t2_wrap;
        t_t1_cont;
        t_t1_oneshot;
        t_irq;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule